// File: doc/BRIEF.md
# Channel-Indexed Configuration Register File

This block holds the configuration bytes of a multi-channel converter front end. Software reaches it through a plain register port: a 10-bit address, 8-bit write data, a write strobe, a read strobe and 8-bit read data. Some registers exist once for the whole device and are called global. Others are local: each of the six channels keeps its own copy.

A global index register decides which local copies an access reaches. Each set bit of the index selects one channel. A local write lands in every selected channel in the same cycle, so a single write can configure a group of channels or all of them. A read always returns exactly one copy, taken from the lowest-numbered selected channel.

Writing the control byte with both reset bits set reloads every register with its default. The current value of every register copy is also presented on a flat output bus, where the rest of the chip picks up its settings.

Top module: `chcfg_regfile`

## Requirements
- R1: After `rst_n` is released, the index register (0x005) reads 0x3F. The local registers reset to 0x00D=0x00, 0x014=0x01 and 0x016=0x03 in every channel. The global registers reset to 0x008=0x00, 0x021=0x30 and 0x109=0x00.
- R2: A write to a local register (0x00D, 0x014 or 0x016) updates the copy of channel c for every set bit c of index bits [5:0]. Copies of channels whose bit is clear keep their value. When the index is 0x00, no copy changes.
- R3: A read of a local register returns the copy of the lowest-numbered channel whose index bit is set. This gives channel 0 when all bits are set. When the index is 0x00, channel 0 is returned.
- R4: A write to a global register (0x008, 0x021 or 0x109) takes effect whatever the index holds, including 0x00, and a read returns it whatever the index holds.
- R5: A write to 0x000 with data bit 5 and data bit 2 both set reloads every register, the index included, with its R1 default at that clock edge. A write to 0x000 with only one of the two bits set changes nothing.
- R6: Address 0x000 always reads 0x00.
- R7: Unimplemented bits read 0 and ignore written values. The valid bit masks are 0x005:0x3F, 0x008:0x03, 0x00D:0x3F, 0x014:0x07, 0x016:0x0F, 0x021:0xFF and 0x109:0x7F.
- R8: Any address not listed in R1, R6 or R10 (for example 0x013, 0x0FF or 0x3FF) ignores writes and reads 0x00.
- R9: A write takes effect at the clock edge where `wr_en` is high. `rdata` shows the read value from the edge after the one where `rd_en` is high, and holds it until the next read.
- R10: 0x001 reads the device code 0x5C and 0x002 reads the revision code 0x03. Writes to both are ignored.

Top module port bus `cfg_q` holds register slot g and channel c at bits [(g*6+c)*8 +: 8]. The slots are ordered 0x008, 0x00D, 0x014, 0x016, 0x021, 0x109. A global slot shows its single value in all six channel positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 10 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid one cycle after `rd_en` |
| cfg_q | output | 288 | Current value of every register copy |

## Verification
The bench writes local registers with partial index masks, then reads every channel alone through a one-hot index. A design that ignored the mask, or wrote only the first selected channel, would show a wrong channel copy. Reads with several bits set, and with none set, probe the priority rule; the wrong channel's value would come back. Global writes with the index at zero catch a decoder that wrongly gates globals with the mask.

Soft reset is tried with one bit and then both bits of the control byte, to catch a reset that fires on a single bit. Out-of-range addresses and all-ones data expose stray decode hits and unmasked bits as non-zero read data.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 6;

    localparam logic [ADDR_W-1:0] A_CTRL  = 10'h000;
    localparam logic [ADDR_W-1:0] A_ID    = 10'h001;
    localparam logic [ADDR_W-1:0] A_GRADE = 10'h002;
    localparam logic [ADDR_W-1:0] A_INDEX = 10'h005;

    localparam int RST_BIT_HI = 5;
    localparam int RST_BIT_LO = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] dflt;
        logic              per_ch;
    } reg_desc_t;

    // Slot table for the function registers; slot order sets cfg_q layout.
    function automatic reg_desc_t reg_desc(input int idx);
        reg_desc_t d;
        case (idx)
            0:       d = '{10'h008, 8'h03, 8'h00, 1'b0};
            1:       d = '{10'h00D, 8'h3F, 8'h00, 1'b1};
            2:       d = '{10'h014, 8'h07, 8'h01, 1'b1};
            3:       d = '{10'h016, 8'h0F, 8'h03, 1'b1};
            4:       d = '{10'h021, 8'hFF, 8'h30, 1'b0};
            5:       d = '{10'h109, 8'h7F, 8'h00, 1'b0};
            default: d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/chcfg_decode.sv
module chcfg_decode
    import chcfg_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit_map,
    output logic                hit_ctrl,
    output logic                hit_id,
    output logic                hit_grade,
    output logic                hit_index,
    output logic                hit_none
);
    always_comb begin
        for (int g = 0; g < NUM_REGS; g++) begin
            hit_map[g] = (addr == reg_desc(g).addr);
        end
        hit_ctrl  = (addr == A_CTRL);
        hit_id    = (addr == A_ID);
        hit_grade = (addr == A_GRADE);
        hit_index = (addr == A_INDEX);
        hit_none  = !(|hit_map) && !hit_ctrl && !hit_id && !hit_grade && !hit_index;
    end

    // R8: an address matches at most one register
    always_comb begin
        p_single_hit_r8: assert ($onehot0({hit_map, hit_ctrl, hit_id, hit_grade, hit_index}));
    end
endmodule

// File: rtl/chcfg_pick.sv
module chcfg_pick #(
    parameter int NUM_CH = 6,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] sel,
    output logic [CH_W-1:0]   first
);
    always_comb begin
        first = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (sel[i]) first = CH_W'(i);
        end
    end

    // R3: the chosen channel is selected and no lower one is
    always_comb begin
        if (sel != '0) begin
            p_first_set_r3: assert (sel[first]);
            p_first_lowest_r3: assert ((sel & ((NUM_CH'(1) << first) - NUM_CH'(1))) == '0);
        end
    end
endmodule

// File: rtl/chcfg_reg_copy.sv
module chcfg_reg_copy
    import chcfg_pkg::*;
#(
    parameter int                COPIES = 1,
    parameter logic [DATA_W-1:0] MASK   = '1,
    parameter logic [DATA_W-1:0] DFLT   = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_def,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [COPIES-1:0]              we,
    output logic [COPIES-1:0][DATA_W-1:0]  q
);
    localparam logic [DATA_W-1:0] RST_VAL = DFLT & MASK;

    typedef struct packed {
        logic [COPIES-1:0][DATA_W-1:0] val;
    } copy_st_t;

    copy_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < COPIES; c++) begin
            if (load_def) begin
                s_d.val[c] = RST_VAL;
            end else if (we[c]) begin
                s_d.val[c] = wdata & MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.val <= {COPIES{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.val;

    for (genvar c = 0; c < COPIES; c++) begin : g_chk
        // R2: a copy without a write or reload keeps its value
        p_unsel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!we[c] && !load_def) |=> $stable(q[c]));
        // R5: reload restores the default
        p_default_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            load_def |=> (q[c] == RST_VAL));
    end
endmodule

// File: rtl/chcfg_regfile.sv
module chcfg_regfile
    import chcfg_pkg::*;
#(
    parameter int                NUM_CH   = 6,
    parameter logic [DATA_W-1:0] CHIP_ID  = 8'h5C,
    parameter logic [DATA_W-1:0] GRADE_ID = 8'h03
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              wr_en,
    input  logic                              rd_en,
    output logic [DATA_W-1:0]                 rdata,
    output logic [NUM_REGS*NUM_CH*DATA_W-1:0] cfg_q
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'((1 << NUM_CH) - 1);

    logic [NUM_REGS-1:0] hit_map;
    logic                hit_ctrl, hit_id, hit_grade, hit_index, hit_none;
    logic                soft_rst;
    logic [0:0][DATA_W-1:0] idx_raw;
    logic [NUM_CH-1:0]   idx_sel;
    logic [CH_W-1:0]     first_ch;
    logic [NUM_REGS-1:0][NUM_CH-1:0][DATA_W-1:0] all_q;

    chcfg_decode u_decode (
        .addr      (addr),
        .hit_map   (hit_map),
        .hit_ctrl  (hit_ctrl),
        .hit_id    (hit_id),
        .hit_grade (hit_grade),
        .hit_index (hit_index),
        .hit_none  (hit_none)
    );

    assign soft_rst = wr_en && hit_ctrl && wdata[RST_BIT_HI] && wdata[RST_BIT_LO];

    chcfg_reg_copy #(
        .COPIES (1),
        .MASK   (IDX_MASK),
        .DFLT   (IDX_MASK)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_def (soft_rst),
        .wdata    (wdata),
        .we       (wr_en && hit_index),
        .q        (idx_raw)
    );

    assign idx_sel = idx_raw[0][NUM_CH-1:0];

    chcfg_pick #(.NUM_CH(NUM_CH)) u_pick (
        .sel   (idx_sel),
        .first (first_ch)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam reg_desc_t D = reg_desc(g);
        if (D.per_ch) begin : g_local
            logic [NUM_CH-1:0] we_c;
            assign we_c = {NUM_CH{wr_en && hit_map[g]}} & idx_sel;

            chcfg_reg_copy #(
                .COPIES (NUM_CH),
                .MASK   (D.mask),
                .DFLT   (D.dflt)
            ) u_copy (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_def (soft_rst),
                .wdata    (wdata),
                .we       (we_c),
                .q        (all_q[g])
            );

            for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
                // R2: each selected channel takes the masked write
                p_local_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && hit_map[g] && idx_sel[c]) |=>
                    (all_q[g][c] == ($past(wdata) & D.mask)));
            end
        end else begin : g_global
            logic [0:0][DATA_W-1:0] gq;

            chcfg_reg_copy #(
                .COPIES (1),
                .MASK   (D.mask),
                .DFLT   (D.dflt)
            ) u_copy (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_def (soft_rst),
                .wdata    (wdata),
                .we       (wr_en && hit_map[g]),
                .q        (gq)
            );

            for (genvar c = 0; c < NUM_CH; c++) begin : g_fan
                assign all_q[g][c] = gq[0];
            end

            // R4: a global write lands whatever the index holds
            p_global_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && hit_map[g]) |=> (gq[0] == ($past(wdata) & D.mask)));
        end
    end

    assign cfg_q = all_q;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            r_d.rdata = '0;
            if (hit_id) begin
                r_d.rdata = CHIP_ID;
            end else if (hit_grade) begin
                r_d.rdata = GRADE_ID;
            end else if (hit_index) begin
                r_d.rdata = idx_raw[0];
            end
            for (int g = 0; g < NUM_REGS; g++) begin
                if (hit_map[g]) r_d.rdata = all_q[g][first_ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R6: the control byte reads zero
    p_ctrl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_ctrl) |=> (rdata == '0));
    // R8: unlisted addresses read zero
    p_unlisted_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_none) |=> (rdata == '0));
    // R10: the device code reads back fixed
    p_id_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_id) |=> (rdata == CHIP_ID));
endmodule

// File: tb/tb_chcfg_regfile.sv
module tb_chcfg_regfile;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [6*NCH*8-1:0] cfg_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [9:0] a;
        logic [7:0] e;
        int         r;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    chcfg_regfile dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata),
        .cfg_q (cfg_q)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input int r, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %h expected %h", r, what, got, exp);
        end
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [9:0] a, input logic [7:0] e, input int r);
        exp_t x;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        x.a = a; x.e = e; x.r = r;
        sb.push_back(x);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: a strobe seen at an edge yields data by the next falling edge
    always @(posedge clk) begin
        if (rst_n && rd_en) begin
            exp_t x;
            @(negedge clk);
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected read data: got %h expected none", rdata);
            end else begin
                x = sb.pop_front();
                chk(rdata, x.e, x.r, $sformatf("read %h", x.a));
            end
        end
    end

    function automatic logic [7:0] slot(input int g, input int c);
        return cfg_q[(g*NCH + c)*8 +: 8];
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 watchdog: got hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: defaults
        do_rd(10'h005, 8'h3F, 1);
        do_rd(10'h00D, 8'h00, 1);
        do_rd(10'h014, 8'h01, 1);
        do_rd(10'h016, 8'h03, 1);
        do_rd(10'h008, 8'h00, 1);
        do_rd(10'h021, 8'h30, 1);
        do_rd(10'h109, 8'h00, 1);
        for (int c = 0; c < NCH; c++) chk(slot(2, c), 8'h01, 1, "cfg_q 014 reset");

        // R10: fixed codes ignore writes
        do_rd(10'h001, 8'h5C, 10);
        do_rd(10'h002, 8'h03, 10);
        do_wr(10'h001, 8'hFF);
        do_wr(10'h002, 8'h00);
        do_rd(10'h001, 8'h5C, 10);
        do_rd(10'h002, 8'h03, 10);

        // R6
        do_rd(10'h000, 8'h00, 6);

        // R2: broadcast then partial mask
        do_wr(10'h014, 8'h05);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) chk(slot(2, c), 8'h05, 2, "broadcast 014");
        do_wr(10'h005, 8'h05);
        do_wr(10'h014, 8'h02);
        for (int c = 0; c < NCH; c++) begin
            do_wr(10'h005, 8'(1 << c));
            do_rd(10'h014, (c == 0 || c == 2) ? 8'h02 : 8'h05, 2);
        end

        // R3: priority on multi-bit and empty index
        do_wr(10'h005, 8'h0C);
        do_rd(10'h014, 8'h02, 3);
        do_wr(10'h005, 8'h30);
        do_rd(10'h014, 8'h05, 3);
        do_wr(10'h005, 8'h3F);
        do_rd(10'h014, 8'h02, 3);
        do_wr(10'h005, 8'h00);
        do_rd(10'h014, 8'h02, 3);

        // R7: masks
        do_wr(10'h005, 8'hFF);
        do_rd(10'h005, 8'h3F, 7);
        do_wr(10'h016, 8'hFF);
        do_rd(10'h016, 8'h0F, 7);
        do_wr(10'h109, 8'hFF);
        do_rd(10'h109, 8'h7F, 7);
        do_wr(10'h008, 8'hFC);
        do_rd(10'h008, 8'h00, 7);

        // R4: globals with empty index; R2 local write with empty index
        do_wr(10'h005, 8'h00);
        do_wr(10'h021, 8'hA5);
        do_rd(10'h021, 8'hA5, 4);
        do_wr(10'h008, 8'h03);
        do_rd(10'h008, 8'h03, 4);
        do_wr(10'h00D, 8'h11);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) chk(slot(1, c), 8'h00, 2, "empty index 00D");
        do_wr(10'h005, 8'h20);
        do_rd(10'h021, 8'hA5, 4);

        // R8: unlisted addresses
        do_wr(10'h013, 8'h55);
        do_wr(10'h0FF, 8'h55);
        do_wr(10'h3FF, 8'h55);
        do_rd(10'h013, 8'h00, 8);
        do_rd(10'h0FF, 8'h00, 8);
        do_rd(10'h3FF, 8'h00, 8);
        do_rd(10'h021, 8'hA5, 8);
        do_rd(10'h005, 8'h20, 8);

        // R5: single bit does nothing, both bits reload
        do_wr(10'h000, 8'h20);
        do_rd(10'h021, 8'hA5, 5);
        do_wr(10'h000, 8'h04);
        do_rd(10'h008, 8'h03, 5);
        do_wr(10'h000, 8'h24);
        do_rd(10'h005, 8'h3F, 5);
        do_rd(10'h021, 8'h30, 5);
        do_rd(10'h008, 8'h00, 5);
        do_rd(10'h014, 8'h01, 5);
        do_rd(10'h016, 8'h03, 5);
        do_rd(10'h109, 8'h00, 5);
        do_rd(10'h000, 8'h00, 6);

        // R9: read data holds without a strobe
        do_rd(10'h021, 8'h30, 9);
        repeat (3) @(negedge clk);
        chk(rdata, 8'h30, 9, "hold after read");
        do_wr(10'h021, 8'h77);
        @(negedge clk);
        chk(rdata, 8'h30, 9, "hold across write");
        chk(slot(4, 0), 8'h77, 9, "write same edge");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R9 pending reads: got %0d expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule